// File: doc/BRIEF.md
# Latched-Address One-of-Eight Decoder

This block turns a three-bit address into eight select lines, with exactly one line asserted. A level-sensitive address holder sits in front of the decoder. While the hold input is low, the holder is transparent and the decoder follows the address pins directly. While the hold input is high, the decoder keeps showing the address that was captured, and later changes on the address pins have no effect.

Two output enables gate every line. One enable is active-high and the other is active-low. The enables are not held; they act combinationally at every moment. Several blocks can therefore be cascaded to decode wider addresses. To use the block as a 1-to-8 demultiplexer, hold one enable in its active state and feed a data bit into the other. That bit then appears on the selected line.

A parameter sets whether a selected line is driven high or low. Every unselected line is driven to the opposite level.

The holder is modelled in clocked form. While hold is low, a register samples the address at each rising clock edge, and the decoder uses the live address pins. While hold is high, the decoder uses the register. The captured address is therefore the one present at the last clock edge at which hold was low.

Top module: `lat_decoder`

## Requirements
- R1: While reset is active (rst_ni low), the held address is 0. With hold high and both enables active, the asserted line is line 0, whatever the address pins carry.
- R2: With hold_i low and both enables active (en_i = 1, en_ni = 0), line addr_i is asserted in the same cycle, with no register delay.
- R3: While hold_i stays high, changes on addr_i have no effect on sel_o.
- R4: While hold_i is high, the line asserted is the one indexed by the addr_i value sampled at the last rising clock edge at which hold_i was low.
- R5: When en_i is 0, all eight lines sit at the deasserted level.
- R6: When en_ni is 1, all eight lines sit at the deasserted level.
- R7: When both enables are active, exactly one line is asserted. Its index equals the effective address (addr_i when hold is low, the held value when hold is high).
- R8: With ACTIVE_HIGH = 1, the asserted level is 1 and the deasserted level is 0. With ACTIVE_HIGH = 0, both levels are inverted, so sel_o is the bitwise complement of the ACTIVE_HIGH = 1 result.
- R9: As a demultiplexer, with en_ni held at 0, the selected line carries the value of en_i (adjusted for polarity), and every other line stays deasserted.
- R10: The enables are not held. Toggling them while hold_i is high changes sel_o at once, and it does not disturb the held address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the address holder |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the held address |
| addr_i | input | ADDR_W (3) | Binary address of the line to select |
| hold_i | input | 1 | High freezes the held address; low makes the holder transparent |
| en_i | input | 1 | Active-high output enable |
| en_ni | input | 1 | Active-low output enable |
| sel_o | output | 2**ADDR_W (8) | Select lines; one asserted when both enables are active |

## Verification
Address, enable and polarity effects reach sel_o in the same cycle, through combinational logic only. The bench therefore drives inputs just after a falling edge and samples sel_o one time unit later, inside the same low phase. The one registered result is the held address. It changes only at a rising edge while hold is low. The bench's reference copy updates at that same edge, so every hold and capture check is made in the half-cycle after the edge that set up its expectation. The concurrent properties sample at rising edges. For the capture and hold checks, they compare against the previous edge's inputs through $past.

// File: rtl/lat_decoder_pkg.sv
package lat_decoder_pkg;

    typedef enum logic {
        LAT_OPEN = 1'b0,
        LAT_HOLD = 1'b1
    } lat_mode_e;

    function automatic lat_mode_e mode_of(input logic hold);
        return hold ? LAT_HOLD : LAT_OPEN;
    endfunction

endpackage

// File: rtl/lat_addr_hold.sv
module lat_addr_hold
    import lat_decoder_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              hold_i,
    output logic [ADDR_W-1:0] eff_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } hold_state_t;

    hold_state_t st_d, st_q;
    lat_mode_e   mode;

    always_comb begin
        mode = mode_of(hold_i);
        st_d = st_q;
        if (mode == LAT_OPEN) begin
            st_d.addr = addr_i;
        end
        eff_o = (mode == LAT_OPEN) ? addr_i : st_q.addr;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lat_onehot_dec.sv
module lat_onehot_dec #(
    parameter int ADDR_W = 3,
    localparam int N_OUT = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] idx_i,
    output logic [N_OUT-1:0]  line_o
);

    for (genvar g = 0; g < N_OUT; g++) begin : g_line
        assign line_o[g] = (idx_i == ADDR_W'(g));
    end

endmodule

// File: rtl/lat_out_gate.sv
module lat_out_gate #(
    parameter int N_OUT       = 8,
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic [N_OUT-1:0] line_i,
    input  logic             en_i,
    input  logic             en_ni,
    output logic [N_OUT-1:0] sel_o
);

    logic             en_ok;
    logic [N_OUT-1:0] gated;

    always_comb begin
        en_ok = en_i & ~en_ni;
        gated = en_ok ? line_i : '0;
    end

    if (ACTIVE_HIGH) begin : g_pol_high
        assign sel_o = gated;
    end else begin : g_pol_low
        assign sel_o = ~gated;
    end

endmodule

// File: rtl/lat_decoder.sv
module lat_decoder #(
    parameter int ADDR_W      = 3,
    parameter bit ACTIVE_HIGH = 1'b1,
    localparam int N_OUT      = 1 << ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              hold_i,
    input  logic              en_i,
    input  logic              en_ni,
    output logic [N_OUT-1:0]  sel_o
);

    logic [ADDR_W-1:0] eff_addr;
    logic [N_OUT-1:0]  raw_line;

    lat_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .addr_i (addr_i),
        .hold_i (hold_i),
        .eff_o  (eff_addr)
    );

    lat_onehot_dec #(.ADDR_W(ADDR_W)) u_dec (
        .idx_i  (eff_addr),
        .line_o (raw_line)
    );

    lat_out_gate #(.N_OUT(N_OUT), .ACTIVE_HIGH(ACTIVE_HIGH)) u_gate (
        .line_i (raw_line),
        .en_i   (en_i),
        .en_ni  (en_ni),
        .sel_o  (sel_o)
    );

endmodule

// File: rtl/lat_decoder_chk.sv
module lat_decoder_chk #(
    parameter int ADDR_W      = 3,
    parameter bit ACTIVE_HIGH = 1'b1,
    localparam int N_OUT      = 1 << ADDR_W
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic              hold_i,
    input logic              en_i,
    input logic              en_ni,
    input logic [N_OUT-1:0]  sel_o
);

    logic [N_OUT-1:0] asserted;
    logic             en_act;
    logic             past_ok;

    assign asserted = ACTIVE_HIGH ? sel_o : ~sel_o;
    assign en_act   = en_i & ~en_ni;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) past_ok <= 1'b0;
        else         past_ok <= 1'b1;
    end

    p_idle_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |-> asserted == '0);

    p_idle_enn_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_ni |-> asserted == '0);

    p_one_hot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_act |-> $countones(asserted) == 1);

    p_transparent_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_act && !hold_i) |-> asserted == (N_OUT'(1) << addr_i));

    p_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && en_act && hold_i && !$past(hold_i))
            |-> asserted == (N_OUT'(1) << $past(addr_i)));

    p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && hold_i && $past(hold_i) && en_act && $past(en_act))
            |-> $stable(sel_o));

endmodule

bind lat_decoder lat_decoder_chk #(.ADDR_W(ADDR_W), .ACTIVE_HIGH(ACTIVE_HIGH)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .hold_i (hold_i),
    .en_i   (en_i),
    .en_ni  (en_ni),
    .sel_o  (sel_o)
);

// File: tb/test_lat_decoder.sv
`timescale 1ns/1ps
module test_lat_decoder;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] addr;
    logic       hold;
    logic       en;
    logic       en_n;
    logic [7:0] sel_hi;
    logic [7:0] sel_lo;

    logic [2:0] ref_lat;
    int         n_checks = 0;
    int         n_errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    lat_decoder #(.ADDR_W(3), .ACTIVE_HIGH(1'b1)) i_lat_decoder (
        .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .hold_i (hold),
        .en_i (en), .en_ni (en_n), .sel_o (sel_hi)
    );

    lat_decoder #(.ADDR_W(3), .ACTIVE_HIGH(1'b0)) i_lat_decoder_lo (
        .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .hold_i (hold),
        .en_i (en), .en_ni (en_n), .sel_o (sel_lo)
    );

    // Reference model of the holder, from R1 and R4.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ref_lat <= 3'd0;
        else if (!hold) ref_lat <= addr;
    end

    function automatic logic [7:0] expect_hi();
        logic [2:0] eff;
        eff = hold ? ref_lat : addr;
        return (en && !en_n) ? (8'd1 << eff) : 8'd0;
    endfunction

    task automatic check(input string req);
        logic [7:0] e;
        e = expect_hi();
        n_checks++;
        if (sel_hi !== e) begin
            n_errors++;
            $display("FAIL %s high-polarity: sel=%b expected=%b", req, sel_hi, e);
        end
        n_checks++;
        if (sel_lo !== ~e) begin
            n_errors++;
            $display("FAIL %s R8 low-polarity: sel=%b expected=%b", req, sel_lo, ~e);
        end
    endtask

    task automatic drive(input logic [2:0] a, input logic h, input logic e, input logic en_bar);
        @(negedge clk);
        addr = a; hold = h; en = e; en_n = en_bar;
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; addr = 3'd5; hold = 1'b1; en = 1'b1; en_n = 1'b0;
        repeat (2) @(negedge clk);
        #1 check("R1 in reset");
        rst_n = 1'b1;
        drive(3'd6, 1'b1, 1'b1, 1'b0);
        check("R1 after reset");
    endtask

    task automatic t_transparent();
        for (int a = 0; a < 8; a++) begin
            drive(3'(a), 1'b0, 1'b1, 1'b0);
            check("R2 R7 transparent");
        end
    endtask

    task automatic t_hold();
        for (int a = 0; a < 8; a++) begin
            drive(3'(a), 1'b0, 1'b1, 1'b0);
            drive(3'(a), 1'b1, 1'b1, 1'b0);
            check("R4 capture");
            for (int b = 0; b < 8; b++) begin
                drive(3'(b), 1'b1, 1'b1, 1'b0);
                check("R3 hold");
            end
        end
    endtask

    task automatic t_enables();
        for (int h = 0; h < 2; h++) begin
            for (int c = 0; c < 4; c++) begin
                for (int a = 0; a < 8; a++) begin
                    drive(3'(a), h[0], c[0], c[1]);
                    if (!c[0])     check("R5 en low");
                    else if (c[1]) check("R6 en_n high");
                    else           check("R7 both active");
                end
            end
        end
    endtask

    task automatic t_demux();
        for (int a = 0; a < 8; a++) begin
            for (int d = 0; d < 2; d++) begin
                drive(3'(a), 1'b0, d[0], 1'b0);
                check("R9 demux");
            end
        end
    endtask

    task automatic t_enable_not_held();
        drive(3'd3, 1'b0, 1'b1, 1'b0);
        drive(3'd3, 1'b1, 1'b1, 1'b0);
        drive(3'd7, 1'b1, 1'b0, 1'b0);
        check("R10 en off while held");
        drive(3'd1, 1'b1, 1'b1, 1'b1);
        check("R10 en_n off while held");
        drive(3'd6, 1'b1, 1'b1, 1'b0);
        check("R10 held address kept");
    endtask

    initial begin
        t_reset();
        t_transparent();
        t_hold();
        t_enables();
        t_demux();
        t_enable_not_held();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule